// File: doc/BRIEF.md
# Carry-Save Multiply-Accumulate Unit

This block keeps a running sum of products of two unsigned operand streams. On every clock edge where the valid strobe is high, it forms the product of the two operands. It adds that product to the value already held in an accumulator register and stores the result back. The register drives the unit output and is also fed back into the adder, so the output always shows the total accumulated so far. A synchronous clear restarts the total from zero. A typical use is a dot product: clear the unit, then present eight operand pairs on eight valid cycles.

Partial products are formed with an AND array and reduced by a chain of 3:2 carry-save stages. One carry-propagate adder then resolves the redundant sum and carry vectors into the register input. A mode parameter chooses where the accumulator enters the reduction:

- **Merged mode** (the default): the accumulator is folded into the same carry-save chain as the partial products, so there is a single carry-propagate addition.
- **Split mode**: the product is first resolved on its own and then added to the accumulator.

The register is one bit wider than a full product. Totals beyond that width wrap around.

Top module: `csa_mac_unit`

## Requirements
- R1: On a rising edge with `in_vld` high and `clr` low, `acc_q` becomes the previous `acc_q` plus the unsigned product `op_a * op_b`.
- R2: On a rising edge with `clr` high, `acc_q` becomes zero, whatever the values of `in_vld` and the operands.
- R3: On a rising edge with `clr` low and `in_vld` low, `acc_q` keeps its value.
- R4: The total is kept modulo 2^17 (2^ACC_W): a sum that passes the top of the register wraps and drops the carry out of bit 16.
- R5: A valid cycle in which either operand is zero leaves `acc_q` unchanged.
- R6: After a clear, eight valid cycles leave `acc_q` equal to the sum of the eight products, truncated to 17 bits.
- R7: The result of a valid cycle is visible on `acc_q` right after the edge that samples it: one register stage, with no added pipeline.
- R8: The largest operand pair, 255 × 255 = 65025, is accumulated exactly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| clr | input | 1 | Synchronous clear of the accumulator; has priority over `in_vld` |
| in_vld | input | 1 | High when the operand pair should be accumulated on this edge |
| op_a | input | 8 | First unsigned operand |
| op_b | input | 8 | Second unsigned operand |
| acc_q | output | 17 | Accumulated total, taken straight from the register |

## Verification
The unit is driven with random eight-term operand sequences that start after a clear. These show whether the partial-product rows and the carry-save chain line up column by column, since one misplaced shift or a lost carry corrupts most random totals. Repeated all-ones operands push the total past 2^17, which separates correct modular wrap from a register that saturates or is truncated short. Idle cycles, zero-operand cycles and a clear raised together with valid each isolate one rule of the register's enable and priority logic.

// File: rtl/csm_mac_pkg.sv
package csm_mac_pkg;

   localparam int DEF_A_W   = 8;
   localparam int DEF_B_W   = 8;
   localparam int DEF_ACC_W = 17;

   // Where the accumulator enters the carry-save reduction.
   typedef enum logic {
      SUM_MERGED = 1'b0,   // feedback folded into the partial-product chain
      SUM_SPLIT  = 1'b1    // product resolved first, then added to feedback
   } sum_mode_e;

endpackage

// File: rtl/csm_pp_rows.sv
// AND-array partial products, each row shifted to its column weight.
module csm_pp_rows #(
   parameter int A_W = 8,
   parameter int B_W = 8,
   parameter int W   = 16
) (
   input  logic [A_W-1:0] a_i,
   input  logic [B_W-1:0] b_i,
   output logic [W-1:0]   rows_o [B_W]
);

   generate
      if (W < A_W) begin : g_bad_w
         $error("csm_pp_rows: row width below operand width");
      end
      for (genvar j = 0; j < B_W; j++) begin : g_row
         assign rows_o[j] = ({W{b_i[j]}} & W'(a_i)) << j;
      end
   endgenerate

endmodule

// File: rtl/csm_csa_chain.sv
// Linear chain of 3:2 carry-save stages reducing ROWS vectors to a
// redundant sum/carry pair with no carry propagation.
module csm_csa_chain #(
   parameter int ROWS = 3,
   parameter int W    = 16
) (
   input  logic [W-1:0] rows_i [ROWS],
   output logic [W-1:0] sum_o,
   output logic [W-1:0] cry_o
);

   localparam int STAGES = ROWS - 1;

   logic [W-1:0] s_n [STAGES];
   logic [W-1:0] c_n [STAGES];

   generate
      if (ROWS < 2) begin : g_bad_rows
         $error("csm_csa_chain: needs at least two rows");
      end
      assign s_n[0] = rows_i[0];
      assign c_n[0] = rows_i[1];
      for (genvar k = 1; k < STAGES; k++) begin : g_stage
         assign s_n[k] = s_n[k-1] ^ c_n[k-1] ^ rows_i[k+1];
         assign c_n[k] = ((s_n[k-1] & c_n[k-1]) |
                          (s_n[k-1] & rows_i[k+1]) |
                          (c_n[k-1] & rows_i[k+1])) << 1;
      end
   endgenerate

   assign sum_o = s_n[STAGES-1];
   assign cry_o = c_n[STAGES-1];

endmodule

// File: rtl/csm_cpa.sv
// Final carry-propagate adder; the carry out of the top bit is dropped.
module csm_cpa #(
   parameter int W = 16
) (
   input  logic [W-1:0] x_i,
   input  logic [W-1:0] y_i,
   output logic [W-1:0] s_o
);

   logic c;

   always_comb begin
      c = 1'b0;
      for (int i = 0; i < W; i++) begin
         s_o[i] = x_i[i] ^ y_i[i] ^ c;
         c      = (x_i[i] & y_i[i]) | (c & (x_i[i] ^ y_i[i]));
      end
   end

endmodule

// File: rtl/csa_mac_unit.sv
module csa_mac_unit
   import csm_mac_pkg::*;
#(
   parameter int        A_W   = DEF_A_W,
   parameter int        B_W   = DEF_B_W,
   parameter int        ACC_W = DEF_ACC_W,
   parameter sum_mode_e MODE  = SUM_MERGED
) (
   input  logic             clk,
   input  logic             clr,
   input  logic             in_vld,
   input  logic [A_W-1:0]   op_a,
   input  logic [B_W-1:0]   op_b,
   output logic [ACC_W-1:0] acc_q
);

   localparam int PROD_W = A_W + B_W;

   logic [ACC_W-1:0] nxt_sum;

   generate
      if (ACC_W < PROD_W) begin : g_bad_acc
         $error("csa_mac_unit: accumulator narrower than a product");
      end
      if (B_W < 2 || A_W < 1) begin : g_bad_ops
         $error("csa_mac_unit: operand widths too small");
      end

      if (MODE == SUM_MERGED) begin : g_merged
         localparam int ROWS = B_W + 1;
         logic [ACC_W-1:0] pp   [B_W];
         logic [ACC_W-1:0] rows [ROWS];
         logic [ACC_W-1:0] vs, vc;

         csm_pp_rows #(.A_W(A_W), .B_W(B_W), .W(ACC_W)) u_pp (
            .a_i(op_a), .b_i(op_b), .rows_o(pp));
         for (genvar r = 0; r < B_W; r++) begin : g_cp
            assign rows[r] = pp[r];
         end
         assign rows[B_W] = acc_q;

         csm_csa_chain #(.ROWS(ROWS), .W(ACC_W)) u_tree (
            .rows_i(rows), .sum_o(vs), .cry_o(vc));
         csm_cpa #(.W(ACC_W)) u_cpa (
            .x_i(vs), .y_i(vc), .s_o(nxt_sum));
      end else begin : g_split
         logic [PROD_W-1:0] pp [B_W];
         logic [PROD_W-1:0] ps, pc, prod;
         logic [ACC_W-1:0]  arows [2];
         logic [ACC_W-1:0]  as_v, ac_v;

         csm_pp_rows #(.A_W(A_W), .B_W(B_W), .W(PROD_W)) u_pp (
            .a_i(op_a), .b_i(op_b), .rows_o(pp));
         csm_csa_chain #(.ROWS(B_W), .W(PROD_W)) u_ptree (
            .rows_i(pp), .sum_o(ps), .cry_o(pc));
         csm_cpa #(.W(PROD_W)) u_pcpa (
            .x_i(ps), .y_i(pc), .s_o(prod));

         assign arows[0] = ACC_W'(prod);
         assign arows[1] = acc_q;
         csm_csa_chain #(.ROWS(2), .W(ACC_W)) u_atree (
            .rows_i(arows), .sum_o(as_v), .cry_o(ac_v));
         csm_cpa #(.W(ACC_W)) u_acpa (
            .x_i(as_v), .y_i(ac_v), .s_o(nxt_sum));
      end
   endgenerate

   // Parallel-load accumulator register with feedback.
   always_ff @(posedge clk) begin
      if (clr)         acc_q <= '0;
      else if (in_vld) acc_q <= nxt_sum;
   end

   AST_CLEAR_ZERO: assert property (@(posedge clk)
      clr |=> acc_q == '0); // R2

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (clr)
      !in_vld |=> $stable(acc_q)); // R3

   AST_ACC_STEP: assert property (@(posedge clk) disable iff (clr)
      in_vld |=> acc_q == ACC_W'($past(acc_q) +
                  ACC_W'($past(op_a)) * ACC_W'($past(op_b)))); // R1

   AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (clr)
      (in_vld && (op_a == '0 || op_b == '0)) |=> $stable(acc_q)); // R5

endmodule

// File: tb/csa_mac_unit_tb.sv
module csa_mac_unit_tb_top;

   localparam int ACC_W = 17;
   localparam int MODV  = 1 << ACC_W;

   logic             clk = 1'b0;
   logic             clr;
   logic             in_vld;
   logic [7:0]       op_a;
   logic [7:0]       op_b;
   logic [ACC_W-1:0] acc_q;

   int n_cmp = 0;
   int n_bad = 0;
   int model = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   csa_mac_unit dut_i (
      .clk(clk), .clr(clr), .in_vld(in_vld),
      .op_a(op_a), .op_b(op_b), .acc_q(acc_q));

   task automatic check(input string req);
      n_cmp++;
      if (int'(acc_q) !== model) begin
         n_bad++;
         $display("FAIL %s: acc_q=%0d expected=%0d", req, acc_q, model);
      end
   endtask

   // Inputs are set at the falling edge, take effect at the next rising
   // edge, and the register is compared at the following falling edge (R7).
   task automatic step(input bit c, input bit v, input int a, input int b,
                       input string req);
      clr = c; in_vld = v; op_a = 8'(a); op_b = 8'(b);
      @(posedge clk);
      if (c)      model = 0;
      else if (v) model = (model + a * b) % MODV;
      @(negedge clk);
      check(req);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(8 * 200000);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: expired, expected run to finish");
      finish_run();
   end

   initial begin
      clr = 1'b1; in_vld = 1'b0; op_a = '0; op_b = '0;
      @(negedge clk);
      step(1, 0, 0, 0, "R2 reset state");

      // R6, R1, R7: random eight-term dot products after a clear
      for (int s = 0; s < 40; s++) begin
         step(1, 0, 0, 0, "R2 clear before sequence");
         for (int t = 0; t < 8; t++)
            step(0, 1, $urandom_range(0, 255), $urandom_range(0, 255),
                 "R6 eight-term sequence");
      end

      // R8 and R4: largest operands repeated until the total wraps
      step(1, 0, 0, 0, "R2 clear");
      step(0, 1, 255, 255, "R8 max product");
      for (int t = 0; t < 6; t++) step(0, 1, 255, 255, "R4 wrap modulo 2^17");

      // R3: idle cycles with operands moving
      for (int t = 0; t < 5; t++)
         step(0, 0, $urandom_range(1, 255), $urandom_range(1, 255), "R3 idle hold");

      // R5: zero operand on either side
      step(0, 1, 0, 200, "R5 zero op_a");
      step(0, 1, 177, 0, "R5 zero op_b");

      // R2: clear wins over valid
      step(0, 1, 99, 98, "R1 accumulate");
      step(1, 1, 255, 255, "R2 clear priority over valid");

      // R7: one-cycle latency, back-to-back valid with gaps
      for (int t = 0; t < 200; t++)
         step(0, $urandom_range(0, 1), $urandom_range(0, 255),
              $urandom_range(0, 255), "R7 mixed valid stream");

      finish_run();
   end

endmodule